// File: doc/BRIEF.md
# Bus-Mastering Thermal Sensor Sequencer

This block collects temperature-sensor voltages without owning a converter. On a programmable schedule it takes over a simple request/acknowledge bus and drives a shared ADC that sits elsewhere on that bus. For each enabled sensing point it steers the analog sensor mux and the ADC input mux, then starts a conversion. It reads the ADC data word at a programmed spacing until a configurable valid bit reports completion, and it stores the converted voltage in that point's result register.

All targets are set by configuration inputs: the bus addresses, the sensor-select word for each point, the ADC channel word, the position and polarity of the valid bit, the right shift applied to the data, and the timing intervals. A poll timeout stops the wait on a conversion that never completes. The block does not convert voltages to temperatures and does not compare them against thresholds.

Top module: `tsense_bus_sequencer`

## Requirements
- R1: The round timer starts a measurement round every `cfg_unit * 256 * cfg_round_ivl` clock cycles, counted from reset release. If `cfg_unit` or `cfg_round_ivl` is zero, no round starts and the bus stays idle.
- R2: A round visits the sensing points in ascending index order and skips every point whose bit in `cfg_pt_en` is 0. For an enabled point the bus order is: sensor-mux write, ADC-mux write, ADC-enable write, then data reads until the point completes.
- R3: The sensor-mux write carries that point's select word (`cfg_sel_val[32*i +: 32]`) to `cfg_sns_addr`. The ADC-mux write sends `cfg_chan_word` to `cfg_mux_addr`, the enable write sends `cfg_chan_word` to `cfg_en_addr`, and every read goes to `cfg_data_addr`.
- R4: The sensor-mux write is issued only when `cfg_wr_sns` is 1, and the ADC-mux write only when `cfg_wr_mux` is 1. The enable write is always issued.
- R5: Two successive data reads for the same point start at least `cfg_poll_ivl` and at most `cfg_poll_ivl + 2` cycles apart.
- R6: A read completes the point when bit `cfg_vld_pos` of `bus_rdata` equals `cfg_vld_high`. Active-high polarity (1) means a set bit signals done; active-low (0) means a cleared bit does.
- R7: On completion, `(bus_rdata >> cfg_shift)` truncated to 12 bits is written into the point's slot `res_data[12*i +: 12]`, and `res_upd[i]` pulses for one cycle. At most one update bit is high at a time.
- R8: If a read is not valid and at least `cfg_timeout` cycles have passed since the point's enable write, `poll_timeout` pulses for one cycle. The point is then abandoned and its result is left unchanged. A `cfg_timeout` of all ones disables the timeout, and polling continues indefinitely.
- R9: Once raised, `bus_req` stays high with `bus_we`, `bus_addr` and `bus_wdata` stable until `bus_ack` is sampled high. Only one transaction is outstanding at a time.
- R10: While `rst_n` is low, `bus_req`, `res_upd`, `round_done` and `poll_timeout` are 0, and every result register is 0.
- R11: `round_done` pulses for one cycle after the last point of a round, with no bus transaction in flight. It also pulses for a round in which no point is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_unit | input | 10 | Base time unit, in multiples of 256 cycles |
| cfg_round_ivl | input | 10 | Base units between rounds |
| cfg_poll_ivl | input | 16 | Cycles between data reads |
| cfg_timeout | input | 32 | Poll timeout in cycles; all ones disables it |
| cfg_pt_en | input | 4 | Sensing-point enable mask |
| cfg_sel_val | input | 128 | Sensor-select word for each point, 32 bits per point |
| cfg_sns_addr | input | 32 | Sensor-mux write address |
| cfg_mux_addr | input | 32 | ADC mux-clear write address |
| cfg_en_addr | input | 32 | ADC enable-set write address |
| cfg_data_addr | input | 32 | ADC data read address |
| cfg_chan_word | input | 32 | ADC channel bit word |
| cfg_wr_sns | input | 1 | Enable for the sensor-mux write |
| cfg_wr_mux | input | 1 | Enable for the ADC-mux write |
| cfg_vld_pos | input | 5 | Bit position of the valid flag in the data word |
| cfg_vld_high | input | 1 | Valid flag polarity, 1 = active high |
| cfg_shift | input | 5 | Right shift applied to the data word |
| bus_req | output | 1 | Transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Transaction address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transaction acknowledge, one cycle |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| res_data | output | 48 | Result slots, 12 bits per point |
| res_upd | output | 4 | One-cycle update strobe for each point |
| round_done | output | 1 | One-cycle end-of-round pulse |
| poll_timeout | output | 1 | One-cycle poll-timeout pulse |

## Verification
The bench builds the block with its default parameters: four sensing points, a 256-cycle prescale, a 32-bit bus and a 32-bit timeout counter. With a unit value of 1, rounds are only a few hundred cycles apart, so round spacing is measured to the exact cycle. The full four-point mask and the all-ones timeout disable are both exercised at real width. Valid positions at bit 0, bit 31 and in mid-word, together with shifts from 0 to 8, show that the valid flag and the 12-bit data field are extracted independently.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PICK,
      ST_WSNS,
      ST_WMUX,
      ST_WEN,
      ST_WAIT,
      ST_READ
   } seq_st_t;
endpackage

// File: rtl/tseq_timer.sv
// Round scheduler: prescale of unit * 2^TICK_SHIFT cycles, then ivl base units.
module tseq_timer #(
   parameter int IVL_W      = 10,
   parameter int TICK_SHIFT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IVL_W-1:0] cfg_unit,
   input  logic [IVL_W-1:0] cfg_ivl,
   output logic             round_go
);
   localparam int PRE_W = IVL_W + TICK_SHIFT;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] lim;
   logic [IVL_W-1:0] rnd_q;
   logic             run;

   assign run = (cfg_unit != '0) && (cfg_ivl != '0);
   assign lim = {cfg_unit, {TICK_SHIFT{1'b0}}} - PRE_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q    <= '0;
         rnd_q    <= '0;
         round_go <= 1'b0;
      end else begin
         round_go <= 1'b0;
         if (!run) begin
            pre_q <= '0;
            rnd_q <= '0;
         end else if (pre_q == lim) begin
            pre_q <= '0;
            if (rnd_q == cfg_ivl - IVL_W'(1)) begin
               rnd_q    <= '0;
               round_go <= 1'b1;
            end else begin
               rnd_q <= rnd_q + IVL_W'(1);
            end
         end else begin
            pre_q <= pre_q + PRE_W'(1);
         end
      end
   end
endmodule

// File: rtl/tseq_extract.sv
// Valid-flag test and voltage field extraction from an ADC data word.
module tseq_extract #(
   parameter int DW    = 32,
   parameter int RES_W = 12,
   parameter int POS_W = 5
) (
   input  logic [DW-1:0]    rdata,
   input  logic [POS_W-1:0] vld_pos,
   input  logic             vld_high,
   input  logic [POS_W-1:0] shift,
   output logic             ready,
   output logic [RES_W-1:0] volt
);
   logic [DW-1:0] shifted;

   assign ready   = (rdata[vld_pos] == vld_high);
   assign shifted = rdata >> shift;
   assign volt    = shifted[RES_W-1:0];
endmodule

// File: rtl/tseq_fsm.sv
// Per-round point walker and single-outstanding bus master.
module tseq_fsm
   import tseq_pkg::*;
#(
   parameter int NPTS   = 4,
   parameter int AW     = 32,
   parameter int DW     = 32,
   parameter int POLL_W = 16,
   parameter int TO_W   = 32,
   parameter int IDX_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               round_go,
   input  logic [NPTS-1:0]    cfg_pt_en,
   input  logic [NPTS*DW-1:0] cfg_sel_val,
   input  logic [AW-1:0]      cfg_sns_addr,
   input  logic [AW-1:0]      cfg_mux_addr,
   input  logic [AW-1:0]      cfg_en_addr,
   input  logic [AW-1:0]      cfg_data_addr,
   input  logic [DW-1:0]      cfg_chan_word,
   input  logic               cfg_wr_sns,
   input  logic               cfg_wr_mux,
   input  logic [POLL_W-1:0]  cfg_poll_ivl,
   input  logic [TO_W-1:0]    cfg_timeout,
   input  logic               rd_ready,
   output logic               bus_req,
   output logic               bus_we,
   output logic [AW-1:0]      bus_addr,
   output logic [DW-1:0]      bus_wdata,
   input  logic               bus_ack,
   output logic               cap_stb,
   output logic [IDX_W-1:0]   cap_idx,
   output logic               round_done,
   output logic               poll_timeout
);
   seq_st_t           st_q, st_nx;
   logic [IDX_W-1:0]  idx_q;
   logic [POLL_W-1:0] wcnt_q;
   logic [POLL_W:0]   wnext;
   logic [TO_W-1:0]   tcnt_q;
   logic [DW-1:0]     sel_cur;
   logic              pt_on, idx_end, to_hit;
   logic              launch, idx_clr, idx_inc, wclr, tclr, done_p, tout_p;

   always_comb begin
      sel_cur = '0;
      pt_on   = 1'b0;
      for (int k = 0; k < NPTS; k++) begin
         if (idx_q == IDX_W'(k)) begin
            sel_cur = cfg_sel_val[k*DW +: DW];
            pt_on   = cfg_pt_en[k];
         end
      end
   end

   assign idx_end = (idx_q == IDX_W'(NPTS));
   assign wnext   = {1'b0, wcnt_q} + {{POLL_W{1'b0}}, 1'b1};
   assign to_hit  = (cfg_timeout != '1) && (tcnt_q >= cfg_timeout);
   assign cap_idx = idx_q;

   always_comb begin
      st_nx   = st_q;
      launch  = 1'b0;
      idx_clr = 1'b0;
      idx_inc = 1'b0;
      wclr    = 1'b0;
      tclr    = 1'b0;
      done_p  = 1'b0;
      tout_p  = 1'b0;
      cap_stb = 1'b0;
      unique case (st_q)
         ST_IDLE: if (round_go) begin
            idx_clr = 1'b1;
            st_nx   = ST_PICK;
         end
         ST_PICK: begin
            if (idx_end) begin
               done_p = 1'b1;
               st_nx  = ST_IDLE;
            end else if (pt_on) begin
               launch = 1'b1;
               st_nx  = cfg_wr_sns ? ST_WSNS : (cfg_wr_mux ? ST_WMUX : ST_WEN);
            end else begin
               idx_inc = 1'b1;
            end
         end
         ST_WSNS: if (bus_ack) begin
            launch = 1'b1;
            st_nx  = cfg_wr_mux ? ST_WMUX : ST_WEN;
         end
         ST_WMUX: if (bus_ack) begin
            launch = 1'b1;
            st_nx  = ST_WEN;
         end
         ST_WEN: if (bus_ack) begin
            wclr  = 1'b1;
            tclr  = 1'b1;
            st_nx = ST_WAIT;
         end
         ST_WAIT: if (wnext >= {1'b0, cfg_poll_ivl}) begin
            launch = 1'b1;
            st_nx  = ST_READ;
         end
         ST_READ: if (bus_ack) begin
            if (rd_ready) begin
               cap_stb = 1'b1;
               idx_inc = 1'b1;
               st_nx   = ST_PICK;
            end else if (to_hit) begin
               tout_p  = 1'b1;
               idx_inc = 1'b1;
               st_nx   = ST_PICK;
            end else begin
               wclr  = 1'b1;
               st_nx = ST_WAIT;
            end
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         idx_q        <= '0;
         wcnt_q       <= '0;
         tcnt_q       <= '0;
         bus_req      <= 1'b0;
         bus_we       <= 1'b0;
         bus_addr     <= '0;
         bus_wdata    <= '0;
         round_done   <= 1'b0;
         poll_timeout <= 1'b0;
      end else begin
         st_q         <= st_nx;
         round_done   <= done_p;
         poll_timeout <= tout_p;
         if (idx_clr)      idx_q <= '0;
         else if (idx_inc) idx_q <= idx_q + IDX_W'(1);
         if (wclr)                 wcnt_q <= '0;
         else if (st_q == ST_WAIT) wcnt_q <= wcnt_q + POLL_W'(1);
         if (tclr) tcnt_q <= '0;
         else if ((st_q == ST_WAIT || st_q == ST_READ) && tcnt_q != '1)
            tcnt_q <= tcnt_q + TO_W'(1);
         if (launch) begin
            bus_req <= 1'b1;
            unique case (st_nx)
               ST_WSNS: begin bus_we <= 1'b1; bus_addr <= cfg_sns_addr;  bus_wdata <= sel_cur;       end
               ST_WMUX: begin bus_we <= 1'b1; bus_addr <= cfg_mux_addr;  bus_wdata <= cfg_chan_word; end
               ST_WEN:  begin bus_we <= 1'b1; bus_addr <= cfg_en_addr;   bus_wdata <= cfg_chan_word; end
               default: begin bus_we <= 1'b0; bus_addr <= cfg_data_addr; bus_wdata <= '0;            end
            endcase
         end else if (bus_ack) begin
            bus_req <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tsense_bus_sequencer.sv
module tsense_bus_sequencer #(
   parameter int NPTS       = 4,
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int RES_W      = 12,
   parameter int IVL_W      = 10,
   parameter int TICK_SHIFT = 8,
   parameter int POLL_W     = 16,
   parameter int TO_W       = 32,
   localparam int POS_W     = $clog2(DW),
   localparam int IDX_W     = $clog2(NPTS + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [IVL_W-1:0]      cfg_unit,
   input  logic [IVL_W-1:0]      cfg_round_ivl,
   input  logic [POLL_W-1:0]     cfg_poll_ivl,
   input  logic [TO_W-1:0]       cfg_timeout,
   input  logic [NPTS-1:0]       cfg_pt_en,
   input  logic [NPTS*DW-1:0]    cfg_sel_val,
   input  logic [AW-1:0]         cfg_sns_addr,
   input  logic [AW-1:0]         cfg_mux_addr,
   input  logic [AW-1:0]         cfg_en_addr,
   input  logic [AW-1:0]         cfg_data_addr,
   input  logic [DW-1:0]         cfg_chan_word,
   input  logic                  cfg_wr_sns,
   input  logic                  cfg_wr_mux,
   input  logic [POS_W-1:0]      cfg_vld_pos,
   input  logic                  cfg_vld_high,
   input  logic [POS_W-1:0]      cfg_shift,
   output logic                  bus_req,
   output logic                  bus_we,
   output logic [AW-1:0]         bus_addr,
   output logic [DW-1:0]         bus_wdata,
   input  logic                  bus_ack,
   input  logic [DW-1:0]         bus_rdata,
   output logic [NPTS*RES_W-1:0] res_data,
   output logic [NPTS-1:0]       res_upd,
   output logic                  round_done,
   output logic                  poll_timeout
);
   if (NPTS < 1 || NPTS > 8) begin : g_bad_npts
      $error("NPTS must lie in 1..8");
   end
   if (RES_W > DW) begin : g_bad_resw
      $error("RES_W must not exceed DW");
   end
   if (TICK_SHIFT < 1) begin : g_bad_tick
      $error("TICK_SHIFT must be at least 1");
   end

   logic             round_go;
   logic             rd_ready;
   logic [RES_W-1:0] volt;
   logic             cap_stb;
   logic [IDX_W-1:0] cap_idx;

   tseq_timer #(.IVL_W(IVL_W), .TICK_SHIFT(TICK_SHIFT)) u_timer (
      .clk(clk), .rst_n(rst_n), .cfg_unit(cfg_unit), .cfg_ivl(cfg_round_ivl),
      .round_go(round_go)
   );

   tseq_extract #(.DW(DW), .RES_W(RES_W), .POS_W(POS_W)) u_extract (
      .rdata(bus_rdata), .vld_pos(cfg_vld_pos), .vld_high(cfg_vld_high),
      .shift(cfg_shift), .ready(rd_ready), .volt(volt)
   );

   tseq_fsm #(
      .NPTS(NPTS), .AW(AW), .DW(DW), .POLL_W(POLL_W), .TO_W(TO_W), .IDX_W(IDX_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .round_go(round_go),
      .cfg_pt_en(cfg_pt_en), .cfg_sel_val(cfg_sel_val),
      .cfg_sns_addr(cfg_sns_addr), .cfg_mux_addr(cfg_mux_addr),
      .cfg_en_addr(cfg_en_addr), .cfg_data_addr(cfg_data_addr),
      .cfg_chan_word(cfg_chan_word), .cfg_wr_sns(cfg_wr_sns), .cfg_wr_mux(cfg_wr_mux),
      .cfg_poll_ivl(cfg_poll_ivl), .cfg_timeout(cfg_timeout), .rd_ready(rd_ready),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .cap_stb(cap_stb), .cap_idx(cap_idx),
      .round_done(round_done), .poll_timeout(poll_timeout)
   );

   for (genvar g = 0; g < NPTS; g++) begin : g_slot
      logic hit;
      assign hit = cap_stb && (cap_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_data[g*RES_W +: RES_W] <= '0;
            res_upd[g]                 <= 1'b0;
         end else begin
            res_upd[g] <= hit;
            if (hit) res_data[g*RES_W +: RES_W] <= volt;
         end
      end
   end
endmodule

// File: rtl/tseq_chk.sv
module tseq_chk #(
   parameter int NPTS = 4,
   parameter int AW   = 32,
   parameter int DW   = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_req,
   input logic            bus_we,
   input logic [AW-1:0]   bus_addr,
   input logic [DW-1:0]   bus_wdata,
   input logic            bus_ack,
   input logic [AW-1:0]   cfg_sns_addr,
   input logic [AW-1:0]   cfg_mux_addr,
   input logic [AW-1:0]   cfg_en_addr,
   input logic [AW-1:0]   cfg_data_addr,
   input logic            cfg_wr_sns,
   input logic [NPTS-1:0] res_upd,
   input logic            round_done,
   input logic            poll_timeout
);
   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));
   // R3
   read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_we |-> bus_addr == cfg_data_addr);
   // R4
   sns_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_we && bus_addr == cfg_sns_addr && cfg_sns_addr != cfg_mux_addr &&
      cfg_sns_addr != cfg_en_addr |-> cfg_wr_sns);
   // R7
   upd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(res_upd));
   // R7
   upd_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |res_upd |-> $past(bus_req && bus_ack && !bus_we));
   // R8
   tout_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll_timeout |-> $past(bus_req && bus_ack && !bus_we) && res_upd == '0);
   // R11
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      round_done |-> !bus_req && $past(!bus_req));
   // R10
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !bus_req && res_upd == '0);
endmodule

bind tsense_bus_sequencer tseq_chk #(.NPTS(NPTS), .AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_ack(bus_ack), .cfg_sns_addr(cfg_sns_addr),
   .cfg_mux_addr(cfg_mux_addr), .cfg_en_addr(cfg_en_addr), .cfg_data_addr(cfg_data_addr),
   .cfg_wr_sns(cfg_wr_sns), .res_upd(res_upd), .round_done(round_done),
   .poll_timeout(poll_timeout)
);

// File: tb/sim_tsense_bus_sequencer.sv
`timescale 1ns/1ps
module sim_tsense_bus_sequencer;
   localparam logic [31:0] A_SNS = 32'h1000_0604;
   localparam logic [31:0] A_MUX = 32'h1100_000C;
   localparam logic [31:0] A_EN  = 32'h1100_0008;
   localparam logic [31:0] A_DAT = 32'h1100_0040;
   localparam logic [31:0] CHAN  = 32'h0000_0800;
   localparam int NVEC = 6;
   // {en[4], wr_sns, wr_mux, vld_pos[5], vld_high, shift[4], reads_to_valid[4]}
   localparam logic [19:0] VEC [NVEC] = '{
      {4'hF, 1'b1, 1'b1, 5'd12, 1'b1, 4'd0, 4'd1},
      {4'h3, 1'b1, 1'b0, 5'd20, 1'b1, 4'd4, 4'd3},
      {4'h5, 1'b0, 1'b1, 5'd0,  1'b0, 4'd8, 4'd2},
      {4'h8, 1'b1, 1'b1, 5'd31, 1'b0, 4'd2, 4'd4},
      {4'h1, 1'b0, 1'b0, 5'd16, 1'b1, 4'd0, 4'd1},
      {4'h0, 1'b1, 1'b1, 5'd12, 1'b1, 4'd0, 4'd1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [9:0] c_unit = 10'd1, c_ivl = 10'd1;
   logic [15:0] c_poll = 16'd3;
   logic [31:0] c_to = '1;
   logic [3:0] c_en = '0;
   logic [127:0] c_sel;
   logic c_ws = 1'b0, c_wm = 1'b0, c_high = 1'b1;
   logic [4:0] c_pos = 5'd12, c_sh = 5'd0;
   logic bus_req, bus_we, bus_ack;
   logic [31:0] bus_addr, bus_wdata, bus_rdata;
   logic [47:0] res_data;
   logic [3:0] res_upd;
   logic round_done, poll_timeout;

   int nchk = 0, nfail = 0, cyc = 0, rel = 0;
   int done_cnt, tout_cnt, upd_cnt, ntx, rd_total, nlog, sns_n, rd_n;
   int sns_t [8];
   int rd_t [8];
   logic [31:0] lg_addr [64];
   logic [31:0] lg_wd [64];
   logic lg_we [64];
   logic [31:0] e_addr [64];
   logic [31:0] e_wd [64];
   logic e_we [64];
   int ne;
   logic log_on = 1'b0;
   logic [31:0] m_sel;
   int m_n = 1, m_rem = 0;
   logic m_never = 1'b0;
   logic finished = 1'b0;

   always #10 clk = ~clk;

   for (genvar i = 0; i < 4; i++) begin : g_sel
      assign c_sel[i*32 +: 32] = 32'(40 * i + 9);
   end

   tsense_bus_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .cfg_unit(c_unit), .cfg_round_ivl(c_ivl),
      .cfg_poll_ivl(c_poll), .cfg_timeout(c_to), .cfg_pt_en(c_en), .cfg_sel_val(c_sel),
      .cfg_sns_addr(A_SNS), .cfg_mux_addr(A_MUX), .cfg_en_addr(A_EN),
      .cfg_data_addr(A_DAT), .cfg_chan_word(CHAN), .cfg_wr_sns(c_ws), .cfg_wr_mux(c_wm),
      .cfg_vld_pos(c_pos), .cfg_vld_high(c_high), .cfg_shift(c_sh),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata), .res_data(res_data), .res_upd(res_upd),
      .round_done(round_done), .poll_timeout(poll_timeout)
   );

   function automatic logic [11:0] volt_of(input logic [31:0] s);
      return 12'((s * 53 + 17) & 32'hFFF);
   endfunction

   function automatic logic [31:0] adc_word(input logic [31:0] s, input logic rdy);
      logic [31:0] w;
      w = 32'(volt_of(s)) << c_sh;
      if (32'(c_sh) + 12 < 32 && 5'(c_sh + 5'd12) != c_pos) w[5'(c_sh + 5'd12)] = 1'b1;
      w[c_pos] = (rdy == c_high);
      return w;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Bus slave and ADC model, acting on the falling edge
   always @(negedge clk) begin
      logic rdy;
      cyc++;
      if (bus_req && !bus_ack) begin
         bus_ack = 1'b1;
         ntx++;
         bus_rdata = '0;
         if (bus_we) begin
            if (bus_addr == A_SNS) begin
               m_sel = bus_wdata;
               if (sns_n < 8) sns_t[sns_n] = cyc;
               sns_n++;
            end
            if (bus_addr == A_EN) m_rem = m_n;
         end else begin
            rdy = !m_never && (m_rem <= 1);
            if (!rdy && m_rem > 1) m_rem--;
            bus_rdata = adc_word(m_sel, rdy);
            if (rd_n < 8) rd_t[rd_n] = cyc;
            rd_n++;
            rd_total++;
         end
         if (log_on && nlog < 64) begin
            lg_addr[nlog] = bus_addr;
            lg_we[nlog]   = bus_we;
            lg_wd[nlog]   = bus_wdata;
            nlog++;
         end
      end else begin
         bus_ack = 1'b0;
      end
      if (round_done) done_cnt++;
      if (poll_timeout) tout_cnt++;
      upd_cnt += $countones(res_upd);
   end

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      done_cnt = 0; tout_cnt = 0; upd_cnt = 0; ntx = 0; rd_total = 0;
      nlog = 0; sns_n = 0; rd_n = 0; m_sel = 32'd5; m_rem = 0;
      log_on = 1'b1;
      rst_n = 1'b1;
      rel = cyc;
   endtask

   task automatic wait_done(input int maxc);
      int c = 0;
      while (done_cnt == 0 && c < maxc) begin
         @(negedge clk);
         c++;
      end
      log_on = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic push(input logic [31:0] a, input logic w, input logic [31:0] d);
      e_addr[ne] = a; e_we[ne] = w; e_wd[ne] = d; ne++;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      int wd = 0;
      while (wd < 150000) begin
         @(posedge clk);
         wd++;
      end
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", wd, 150000);
      finish_run();
   end

   initial begin
      bus_ack = 1'b0;
      bus_rdata = '0;
      m_sel = 32'd5;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 bus_req in reset", 32'(bus_req), 0);
      chk("R10 results in reset", 32'(res_data[31:0] | 32'(res_data[47:32])), 0);
      chk("R10 pulses in reset", 32'({res_upd, round_done, poll_timeout}), 0);

      // Vector table walk: R2 R3 R4 R6 R7 R11
      for (int v = 0; v < NVEC; v++) begin
         int mism = 0;
         int n;
         logic [31:0] sel_used;
         {c_en, c_ws, c_wm, c_pos, c_high} = VEC[v][19:8];
         c_sh = 5'(VEC[v][7:4]);
         n = int'(VEC[v][3:0]);
         c_unit = 10'd1; c_ivl = 10'd1; c_poll = 16'd3; c_to = '1;
         m_n = n; m_never = 1'b0;
         do_reset();
         wait_done(1500);
         ne = 0;
         for (int i = 0; i < 4; i++) begin
            if (c_en[i]) begin
               if (c_ws) push(A_SNS, 1'b1, c_sel[i*32 +: 32]);
               if (c_wm) push(A_MUX, 1'b1, CHAN);
               push(A_EN, 1'b1, CHAN);
               for (int r = 0; r < n; r++) push(A_DAT, 1'b0, 32'd0);
            end
         end
         chk("R11 round_done count", 32'(done_cnt), 1);
         chk("R2 R4 transaction count", 32'(nlog), 32'(ne));
         for (int k = 0; k < ne && k < nlog; k++) begin
            if (lg_addr[k] !== e_addr[k] || lg_we[k] !== e_we[k] ||
                (e_we[k] && lg_wd[k] !== e_wd[k])) mism++;
         end
         chk("R3 transaction order and content", 32'(mism), 0);
         chk("R7 update strobes", 32'(upd_cnt), 32'($countones(c_en)));
         for (int i = 0; i < 4; i++) begin
            sel_used = c_ws ? c_sel[i*32 +: 32] : 32'd5;
            chk("R6 R7 result slot", 32'(res_data[i*12 +: 12]),
                c_en[i] ? 32'(volt_of(sel_used)) : 32'd0);
         end
      end

      // R1: round spacing and first round position
      c_unit = 10'd1; c_ivl = 10'd2; c_en = 4'h1; c_ws = 1'b1; c_wm = 1'b0;
      c_pos = 5'd12; c_high = 1'b1; c_sh = 5'd0; m_n = 1;
      do_reset();
      for (int c = 0; c < 3000 && sns_n < 3; c++) @(negedge clk);
      chk("R1 first round delay", 32'(sns_t[0] - rel >= 512 && sns_t[0] - rel <= 520), 1);
      chk("R1 round spacing a", 32'(sns_t[1] - sns_t[0]), 512);
      chk("R1 round spacing b", 32'(sns_t[2] - sns_t[1]), 512);

      // R5: poll spacing for two poll interval settings
      for (int p = 0; p < 2; p++) begin
         int pv;
         pv = (p == 0) ? 10 : 25;
         c_unit = 10'd1; c_ivl = 10'd1; c_ws = 1'b0; c_wm = 1'b0; c_poll = 16'(pv);
         m_n = 3;
         do_reset();
         wait_done(1500);
         chk("R5 read count", 32'(rd_n), 3);
         chk("R5 poll spacing", 32'(rd_t[1] - rd_t[0] >= pv && rd_t[1] - rd_t[0] <= pv + 2 &&
                                    rd_t[2] - rd_t[1] >= pv && rd_t[2] - rd_t[1] <= pv + 2), 1);
      end

      // R8: finite timeout abandons points and keeps results
      c_poll = 16'd4; c_to = 32'd40; c_en = 4'h3; c_ws = 1'b1; c_wm = 1'b1;
      m_never = 1'b1;
      do_reset();
      wait_done(1500);
      chk("R8 timeout pulses", 32'(tout_cnt), 2);
      chk("R8 no update on timeout", 32'(upd_cnt), 0);
      chk("R8 results kept", 32'(res_data[23:0]), 0);
      chk("R11 done after timeouts", 32'(done_cnt), 1);

      // R8: all-ones timeout polls indefinitely
      c_to = '1; c_en = 4'h1;
      do_reset();
      repeat (1500) @(negedge clk);
      chk("R8 disabled timeout no pulse", 32'(tout_cnt), 0);
      chk("R8 disabled timeout still polling", 32'(rd_total > 100 && done_cnt == 0), 1);
      m_rem = 1;
      m_never = 1'b0;
      wait_done(200);
      chk("R8 late completion captured", 32'(res_data[11:0]), 32'(volt_of(c_sel[31:0])));

      // R1: zero unit or zero interval keeps the bus idle
      m_never = 1'b0;
      c_unit = 10'd0; c_ivl = 10'd3;
      do_reset();
      repeat (2000) @(negedge clk);
      chk("R1 zero unit idle", 32'(ntx), 0);
      c_unit = 10'd1; c_ivl = 10'd0;
      do_reset();
      repeat (2000) @(negedge clk);
      chk("R1 zero interval idle", 32'(ntx + done_cnt), 0);

      finish_run();
   end
endmodule